// File: doc/BRIEF.md
# Multi-Precision Fragment Sequencer

This block applies add, subtract, one-bit shifts and bitwise logic to operands much wider than its datapath. Both operands are captured into fragment registers when an operation is accepted. A small controller then steps through the N fragments of W bits, one per clock, and sends each fragment pair through a narrow combinational ALU. Each partial result goes into its own slot of a result store. A single status flop links neighbouring fragments. For arithmetic it carries the carry or borrow. For shifts it carries the bit that crossed the fragment edge.

The walking order depends on the operation. Add, subtract, left shift and the logic operations start at the least-significant fragment. Right shift starts at the most-significant fragment, because each fragment needs the low bit of the fragment above it. Logic operations neither read nor change the status flop. Fragment i always holds bits [i*W +: W] of the wide value. A one-cycle done pulse marks completion, and the final carry and a zero flag remain available until the next operation.

Top module: `mpfrag_seq`

## Requirements
- R1: After reset, result is 0, carry is 0, zero is 1, and busy and done are 0.
- R2: Op code 0 (add) gives result = (A + B) mod 2^(N*W), and carry = bit N*W of the full sum. The first fragment uses a carry-in of 0.
- R3: Op code 1 (subtract) gives result = (A - B) mod 2^(N*W), computed as A + ~B + 1. Carry is 1 exactly when A >= B as unsigned values, and 0 on a borrow.
- R4: Op code 2 (shift left by one) gives result = A << 1 with 0 shifted in. Each fragment's MSB moves into the LSB of the next fragment up. Carry = bit N*W-1 of A.
- R5: Op code 3 (shift right by one) gives result = A >> 1 with 0 shifted in at the top. Each fragment's LSB moves into the MSB of the fragment below. Carry = bit 0 of A.
- R6: Op codes 4, 5 and 6 give A AND B, A OR B and A XOR B, one fragment at a time. Carry keeps the value it had before the operation.
- R7: When done is 1, zero is 1 exactly when every result fragment written by that operation is 0.
- R8: Done is high for exactly one cycle. It rises N clock edges after the edge that accepted start. Busy is high in between, and busy is low while done is high.
- R9: A start that arrives while busy is 1 is ignored. The running operation, its result and its carry are unaffected.
- R10: A start with op code 7 is not accepted. Busy stays 0, and result and carry keep their values.
- R11: A start presented in the cycle where done is high is accepted. The second operation runs with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation; sampled when idle |
| op | input | 3 | Operation code (0 add, 1 sub, 2 shl, 3 shr, 4 and, 5 or, 6 xor, 7 reserved) |
| a_in | input | N*W | Operand A, captured when start is accepted |
| b_in | input | N*W | Operand B, captured when start is accepted |
| busy | output | 1 | Fragments are being processed |
| done | output | 1 | One-cycle completion pulse |
| result | output | N*W | Result store, fragment i in bits [i*W +: W] |
| carry | output | 1 | Carry/status flop |
| zero | output | 1 | All partial results of the operation were zero |

## Verification
Two events can land on the same edge: the write of the last fragment, and a new start request. A start raised on the last busy cycle must be dropped. A start raised in the cycle where done is high must be taken at once. The bench raises a conflicting start part-way through an operation and checks that the first result and carry are intact. It then raises a second request exactly in the done cycle and checks that the second result arrives after exactly N more edges, with its own correct value, carry and done pulse.

// File: rtl/mpfrag_pkg.sv
package mpfrag_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_SHL = 3'd2,
      OP_SHR = 3'd3,
      OP_AND = 3'd4,
      OP_OR  = 3'd5,
      OP_XOR = 3'd6,
      OP_RSV = 3'd7
   } op_e;

   function automatic logic op_is_logic(op_e o);
      return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR);
   endfunction

endpackage

// File: rtl/mpfrag_alu.sv
module mpfrag_alu
   import mpfrag_pkg::*;
#(
   parameter int W = 8
) (
   input  op_e          op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] y,
   output logic         cout
);

   logic [W:0] sum;

   always_comb begin
      sum  = '0;
      y    = '0;
      cout = cin;
      case (op)
         OP_ADD: begin
            sum  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            y    = sum[W-1:0];
            cout = sum[W];
         end
         OP_SUB: begin
            sum  = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, cin};
            y    = sum[W-1:0];
            cout = sum[W];
         end
         OP_SHL: begin
            y    = {a[W-2:0], cin};
            cout = a[W-1];
         end
         OP_SHR: begin
            y    = {cin, a[W-1:1]};
            cout = a[0];
         end
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/mpfrag_ctrl.sv
module mpfrag_ctrl #(
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          op_ok,
   input  logic          down,
   output logic          accept,
   output logic          busy,
   output logic          done,
   output logic [IW-1:0] idx
);

   localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

   logic          busy_q, done_q, down_q;
   logic [IW-1:0] idx_q, left_q;

   assign accept = start && !busy_q && op_ok;
   assign busy   = busy_q;
   assign done   = done_q;
   assign idx    = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         down_q <= 1'b0;
         idx_q  <= '0;
         left_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q <= 1'b1;
            down_q <= down;
            idx_q  <= down ? LAST_IDX : '0;
            left_q <= LAST_IDX;
         end else if (busy_q) begin
            if (left_q == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               left_q <= left_q - 1'b1;
               idx_q  <= down_q ? idx_q - 1'b1 : idx_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/mpfrag_store.sv
module mpfrag_store #(
   parameter int W  = 8,
   parameter int N  = 4,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic [IW-1:0]  idx,
   input  logic [W-1:0]   din,
   input  logic           clr_zero,
   output logic [N*W-1:0] result,
   output logic           zero
);

   logic zero_q;

   for (genvar s = 0; s < N; s++) begin : g_slot
      logic [W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (wr && idx == IW'(s))
            slot_q <= din;
      end
      assign result[s*W +: W] = slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         zero_q <= 1'b1;
      else if (clr_zero)
         zero_q <= 1'b1;
      else if (wr)
         zero_q <= zero_q && (din == '0);
   end

   assign zero = zero_q;

endmodule

// File: rtl/mpfrag_seq.sv
module mpfrag_seq
   import mpfrag_pkg::*;
#(
   parameter int W = 8,
   parameter int N = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [2:0]     op,
   input  logic [N*W-1:0] a_in,
   input  logic [N*W-1:0] b_in,
   output logic           busy,
   output logic           done,
   output logic [N*W-1:0] result,
   output logic           carry,
   output logic           zero
);

   localparam int IW = (N > 1) ? $clog2(N) : 1;
   localparam int NW = N * W;

   if (W < 2) begin : g_bad_w
      $error("mpfrag_seq: W must be at least 2");
   end
   if (N < 2) begin : g_bad_n
      $error("mpfrag_seq: N must be at least 2");
   end

   op_e           op_new, op_q;
   logic [NW-1:0] a_q, b_q;
   logic [IW-1:0] idx;
   logic          accept, cy_q, alu_cout;
   logic [W-1:0]  a_frag, b_frag, alu_y;

   assign op_new = op_e'(op);

   mpfrag_ctrl #(.N(N), .IW(IW)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .op_ok  (op_new != OP_RSV),
      .down   (op_new == OP_SHR),
      .accept (accept),
      .busy   (busy),
      .done   (done),
      .idx    (idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q <= OP_ADD;
         a_q  <= '0;
         b_q  <= '0;
      end else if (accept) begin
         op_q <= op_new;
         a_q  <= a_in;
         b_q  <= b_in;
      end
   end

   assign a_frag = a_q[int'(idx)*W +: W];
   assign b_frag = b_q[int'(idx)*W +: W];

   mpfrag_alu #(.W(W)) u_alu (
      .op   (op_q),
      .a    (a_frag),
      .b    (b_frag),
      .cin  (cy_q),
      .y    (alu_y),
      .cout (alu_cout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cy_q <= 1'b0;
      else if (accept) begin
         case (op_new)
            OP_SUB:                 cy_q <= 1'b1;
            OP_ADD, OP_SHL, OP_SHR: cy_q <= 1'b0;
            default:                cy_q <= cy_q;
         endcase
      end else if (busy && !op_is_logic(op_q))
         cy_q <= alu_cout;
   end

   assign carry = cy_q;

   mpfrag_store #(.W(W), .N(N), .IW(IW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (busy),
      .idx      (idx),
      .din      (alu_y),
      .clr_zero (accept),
      .result   (result),
      .zero     (zero)
   );

endmodule

// File: rtl/mpfrag_chk.sv
module mpfrag_chk #(
   parameter int W = 8,
   parameter int N = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           busy,
   input logic           done,
   input logic [N*W-1:0] result,
   input logic           carry,
   input logic           zero,
   input logic [2:0]     op_q
);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(op_q));

   assert_idle_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(result));

   assert_logic_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_q >= 3'd4) |=> $stable(carry));

   assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (zero == (result == '0)));

endmodule

bind mpfrag_seq mpfrag_chk #(.W(W), .N(N)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .result (result),
   .carry  (carry),
   .zero   (zero),
   .op_q   (op_q)
);

// File: tb/sim_mpfrag_seq.sv
`timescale 1ns/1ps
module sim_mpfrag_seq;

   localparam int W  = 8;
   localparam int N  = 4;
   localparam int NW = N * W;
   localparam int NV = 14;

   localparam logic [66:0] VEC [NV] = '{
      {3'd0, 32'h12345678, 32'h11111111},
      {3'd0, 32'hFFFFFFFF, 32'h00000001},
      {3'd0, 32'h80FF00FF, 32'h80010001},
      {3'd1, 32'h00000000, 32'h00000001},
      {3'd1, 32'h12345678, 32'h12345678},
      {3'd1, 32'h00010000, 32'h00000001},
      {3'd2, 32'h80808080, 32'h00000000},
      {3'd2, 32'h7FFFFFFF, 32'h00000000},
      {3'd3, 32'h80000000, 32'h00000000},
      {3'd3, 32'h01010101, 32'h00000000},
      {3'd4, 32'h0F0F0F0F, 32'hFF00FF00},
      {3'd5, 32'h00000000, 32'h00000000},
      {3'd6, 32'hA5A5A5A5, 32'hFFFF0000},
      {3'd1, 32'h00000010, 32'h00000020}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    op = 3'd0;
   logic [NW-1:0] a_in = '0, b_in = '0;
   logic          busy, done, carry, zero;
   logic [NW-1:0] result;

   int   n_chk = 0;
   int   n_bad = 0;
   logic exp_c = 1'b0;

   always #2.5 clk = ~clk;

   mpfrag_seq #(.W(W), .N(N)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .a_in(a_in), .b_in(b_in), .busy(busy), .done(done),
      .result(result), .carry(carry), .zero(zero)
   );

   function automatic string tag_of(logic [2:0] o);
      case (o)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         default: return "R6";
      endcase
   endfunction

   function automatic logic [NW:0] model(logic [2:0] o, logic [NW-1:0] a,
                                         logic [NW-1:0] b, logic cin);
      case (o)
         3'd0: return {1'b0, a} + {1'b0, b};
         3'd1: return {1'b0, a} + {1'b0, ~b} + 33'd1;
         3'd2: return {a[NW-1], a[NW-2:0], 1'b0};
         3'd3: return {a[0], 1'b0, a[NW-1:1]};
         3'd4: return {cin, a & b};
         3'd5: return {cin, a | b};
         default: return {cin, a ^ b};
      endcase
   endfunction

   task automatic check(string tag, logic [NW-1:0] act, logic [NW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_result(string tag, logic [2:0] o,
                               logic [NW-1:0] a, logic [NW-1:0] b);
      logic [NW:0] m;
      m = model(o, a, b, exp_c);
      check(tag, result, m[NW-1:0]);
      check(tag, NW'(carry), NW'(m[NW]));
      check("R7", NW'(zero), NW'(m[NW-1:0] == '0));
      exp_c = m[NW];
   endtask

   task automatic run_op(logic [2:0] o, logic [NW-1:0] a, logic [NW-1:0] b);
      @(negedge clk);
      start = 1'b1; op = o; a_in = a; b_in = b;
      @(negedge clk);
      start = 1'b0;
      check("R8", NW'(busy), NW'(1));
      repeat (N - 1) @(negedge clk);
      check("R8", NW'(done), NW'(0));
      @(negedge clk);
      check("R8", NW'({done, busy}), NW'(2'b10));
      check_result(tag_of(o), o, a, b);
      @(negedge clk);
      check("R8", NW'(done), NW'(0));
   endtask

   initial begin
      #(200000 * 5.0);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [NW-1:0] keep_r;
      logic          keep_c;
      repeat (3) @(negedge clk);
      check("R1", result, '0);
      check("R1", NW'({busy, done, carry, zero}), NW'(4'b0001));
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++)
         run_op(VEC[v][66:64], VEC[v][63:32], VEC[v][31:0]);

      // R10: reserved op code is not accepted
      keep_r = result; keep_c = carry;
      @(negedge clk);
      start = 1'b1; op = 3'd7; a_in = 32'hDEADBEEF; b_in = 32'h1;
      @(negedge clk);
      start = 1'b0;
      check("R10", NW'(busy), NW'(0));
      repeat (N + 1) @(negedge clk);
      check("R10", result, keep_r);
      check("R10", NW'({carry, done}), NW'({keep_c, 1'b0}));

      // R9: start while busy is ignored
      @(negedge clk);
      start = 1'b1; op = 3'd0; a_in = 32'h000000FF; b_in = 32'h00000001;
      @(negedge clk);
      op = 3'd1; a_in = 32'h55555555; b_in = 32'h12345678;
      repeat (N - 1) @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check("R9", NW'(done), NW'(1));
      check_result("R9", 3'd0, 32'h000000FF, 32'h00000001);

      // R11: start in the done cycle is taken back-to-back
      @(negedge clk);
      start = 1'b1; op = 3'd2; a_in = 32'hC0000001; b_in = '0;
      @(negedge clk);
      start = 1'b0;
      repeat (N - 1) @(negedge clk);
      @(negedge clk);
      check("R11", NW'(done), NW'(1));
      check_result("R4", 3'd2, 32'hC0000001, '0);
      start = 1'b1; op = 3'd3; a_in = 32'h00000003; b_in = '0;
      @(negedge clk);
      start = 1'b0;
      check("R11", NW'(busy), NW'(1));
      repeat (N - 1) @(negedge clk);
      check("R11", NW'(done), NW'(0));
      @(negedge clk);
      check("R11", NW'(done), NW'(1));
      check_result("R11", 3'd3, 32'h00000003, '0);

      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule